// File: doc/BRIEF.md
# Bridge I/O Window Address Decoder

This block holds the I/O window registers of a two-bus bridge and decides, for each I/O access, whether it crosses the bridge. Software programs a window through a small configuration port. The window has a lower bound (base) and an upper bound (limit), each kept at 4KB granularity and extendable to the full 32-bit I/O space. A primary-side access whose address falls in the window is flagged for downstream forwarding. A secondary-side access whose address falls outside the window is flagged for upstream forwarding.

An optional legacy-ISA mode carves holes into the window below 64KB. With the mode on, only the bottom quarter (the first 256 bytes) of each aligned 1KB block in that region goes downstream. The other three quarters go upstream. The two command bits, I/O enable and master enable, gate the downstream flag and the upstream flag respectively. Both flags are combinational. Each depends on its own address, its own valid input and the current register state.

Configuration space is addressed by dword index. Index 07h (byte offset 1Ch) holds the base byte in lane 0 and the limit byte in lane 1. Index 0Ch (30h) holds the base upper half in bits [15:0] and the limit upper half in bits [31:16]. Index 0Fh (3Ch) holds the ISA enable in bit 18. All other bits and indices read as zero.

Top module: `iowin_decoder`

## Requirements
- R1: After reset, index 07h reads 0000_0101h, index 0Ch reads 0, and index 0Fh reads 0. This makes the window cover 0000_0000h to 0000_0FFFh.
- R2: Bits [3:0] and [11:8] of index 07h always read 1h, and writes to those bits have no effect.
- R3: Writes honour byte enables. At index 07h, lane 0 bits [7:4] set base address bits [15:12] and lane 1 bits [15:12] set limit address bits [15:12]. At index 0Ch all 32 bits are read/write, in four byte lanes.
- R4: A valid primary access with base <= address <= limit raises pri_fwd_down in the same cycle. Base bits [11:0] count as 000h and limit bits [11:0] count as FFFh.
- R5: A valid secondary access whose address is outside [base, limit] raises sec_fwd_up in the same cycle.
- R6: When base exceeds limit, pri_fwd_down stays low and every valid secondary access raises sec_fwd_up.
- R7: With ISA enable set, an in-window address that has bits [31:16] = 0 and bits [9:8] != 00 is not forwarded downstream and is forwarded upstream.
- R8: With ISA enable set, in-window addresses with bits [31:16] != 0 are decoded as in R4 and R5, unaffected by the carve-out.
- R9: pri_fwd_down is low whenever cmd_io_en is low.
- R10: sec_fwd_up is low whenever cmd_master_en is low.
- R11: Each flag is low while its valid input is low.
- R12: ISA enable is written through bit 18 under byte enable 2 at index 0Fh and reads back in that position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_dw_idx | input | 6 | Configuration dword index (byte offset / 4) |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_dw_idx, combinational |
| cmd_io_en | input | 1 | Command I/O enable, gates downstream forwarding |
| cmd_master_en | input | 1 | Command master enable, gates upstream forwarding |
| pri_valid | input | 1 | Primary-side I/O access present |
| pri_addr | input | 32 | Primary-side I/O address |
| pri_fwd_down | output | 1 | Forward the primary access downstream |
| sec_valid | input | 1 | Secondary-side I/O access present |
| sec_addr | input | 32 | Secondary-side I/O address |
| sec_fwd_up | output | 1 | Forward the secondary access upstream |

## Verification
The hardest case to reach from the ports is the ISA carve-out at its edges. It requires a window that straddles the 64KB line with ISA mode on, and addresses exactly at 0FFh/100h and 3FFh/400h of a 1KB block. It also requires addresses just above 1_0000h, where the carve-out must stop applying. The stimulus programs such a window through partial byte-enable writes and then steps both address inputs through those edges with equal addresses. A behavioural model in the bench predicts both flags and the read data, and is compared against the outputs every cycle, including during long random runs that reprogram the registers.

// File: rtl/iowin_pkg.sv
// Package: shared widths and configuration indices for the I/O window decoder.
// Assumes dword-indexed configuration access; byte lanes map to wdata bytes.
package iowin_pkg;
    localparam int ADDR_W    = 32;
    localparam int IDX_W     = 6;
    localparam int PAGE_BITS = 12;               // 4KB granularity
    localparam int HI_W      = 16;               // upper extension width
    localparam int NIB_W     = ADDR_W - PAGE_BITS - HI_W;
    localparam int ISA_BIT   = 18;               // in dword IDX_CTRL

    localparam logic [IDX_W-1:0] IDX_LOW  = 6'h07;  // base/limit bytes
    localparam logic [IDX_W-1:0] IDX_HIGH = 6'h0C;  // upper halves
    localparam logic [IDX_W-1:0] IDX_CTRL = 6'h0F;  // ISA enable

    localparam logic [3:0] CAP_32BIT = 4'h1;     // read-only capability nibble

    typedef struct packed {
        logic [HI_W-1:0]  base_hi;
        logic [NIB_W-1:0] base_nib;
        logic [HI_W-1:0]  lim_hi;
        logic [NIB_W-1:0] lim_nib;
        logic             isa_en;
    } iowin_cfg_t;
endpackage

// File: rtl/iowin_cfg_regs.sv
// Module: iowin_cfg_regs
// Holds the I/O window base/limit fields and the ISA enable. Writes are
// byte-enabled and take effect on the clock edge; reads are combinational.
// Assumes cfg_dw_idx is stable while cfg_rdata is used.
module iowin_cfg_regs
    import iowin_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [IDX_W-1:0]  cfg_dw_idx,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output iowin_cfg_t        cfg_q
);
    localparam int LANES = 4;

    logic [31:0]      hi_dw;     // {lim_hi, base_hi}
    logic [NIB_W-1:0] base_nib;
    logic [NIB_W-1:0] lim_nib;
    logic             isa_en;

    logic wr_low, wr_high, wr_ctrl;
    assign wr_low  = cfg_wr && (cfg_dw_idx == IDX_LOW);
    assign wr_high = cfg_wr && (cfg_dw_idx == IDX_HIGH);
    assign wr_ctrl = cfg_wr && (cfg_dw_idx == IDX_CTRL);

    // Byte-lane storage of the upper-half dword, one lane per generate pass.
    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_hi_lane
            // Purpose: update one byte lane of the upper halves.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    hi_dw[g*8 +: 8] <= '0;
                else if (wr_high && cfg_be[g])
                    hi_dw[g*8 +: 8] <= cfg_wdata[g*8 +: 8];
            end
        end
    endgenerate

    // Purpose: update the writable nibbles of the low base/limit bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_nib <= '0;
            lim_nib  <= '0;
        end else if (wr_low) begin
            if (cfg_be[0]) base_nib <= cfg_wdata[7:4];
            if (cfg_be[1]) lim_nib  <= cfg_wdata[15:12];
        end
    end

    // Purpose: update the ISA enable control bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            isa_en <= 1'b0;
        else if (wr_ctrl && cfg_be[2])
            isa_en <= cfg_wdata[ISA_BIT];
    end

    // Purpose: combinational read multiplexer.
    always_comb begin
        cfg_rdata = '0;
        unique case (cfg_dw_idx)
            IDX_LOW:  cfg_rdata = {16'h0000, lim_nib, CAP_32BIT, base_nib, CAP_32BIT};
            IDX_HIGH: cfg_rdata = hi_dw;
            IDX_CTRL: cfg_rdata[ISA_BIT] = isa_en;
            default:  cfg_rdata = '0;
        endcase
    end

    assign cfg_q.base_hi  = hi_dw[15:0];
    assign cfg_q.lim_hi   = hi_dw[31:16];
    assign cfg_q.base_nib = base_nib;
    assign cfg_q.lim_nib  = lim_nib;
    assign cfg_q.isa_en   = isa_en;

    wire unused_wdata_bits = ^{cfg_wdata[31:19], cfg_wdata[17:16],
                               cfg_wdata[11:8], cfg_wdata[3:0], cfg_be[3]};

    // R2: capability nibbles never change, whatever was written.
    assert_cap_nibble_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_dw_idx == IDX_LOW) |-> (cfg_rdata[3:0] == 4'h1 && cfg_rdata[11:8] == 4'h1));

    // R3: a disabled lane of the upper halves keeps its value.
    assert_lane_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_high && !cfg_be[0]) |=> $stable(hi_dw[7:0]));
endmodule

// File: rtl/iowin_match.sv
// Module: iowin_match
// Compares one I/O address against the programmed window and flags the
// ISA carve-out region. Purely combinational. Assumes base has implied
// zeros and limit implied ones in the page-offset bits.
module iowin_match
    import iowin_pkg::*;
(
    input  iowin_cfg_t        cfg,
    input  logic [ADDR_W-1:0] addr,
    output logic              in_win,
    output logic              isa_hole
);
    localparam int PAGE_W = ADDR_W - PAGE_BITS;

    logic [PAGE_W-1:0] base_pg, lim_pg, addr_pg;

    // Purpose: page-granular range compare and carve-out detection.
    always_comb begin
        base_pg  = {cfg.base_hi, cfg.base_nib};
        lim_pg   = {cfg.lim_hi,  cfg.lim_nib};
        addr_pg  = addr[ADDR_W-1:PAGE_BITS];
        in_win   = (addr_pg >= base_pg) && (addr_pg <= lim_pg);
        isa_hole = cfg.isa_en && (addr[ADDR_W-1:16] == '0) && (addr[9:8] != 2'b00);
    end

    wire unused_addr_bits = ^{addr[11:10], addr[7:0]};
endmodule

// File: rtl/iowin_decoder.sv
// Module: iowin_decoder (top)
// Configuration registers plus forwarding decisions for primary (downstream)
// and secondary (upstream) I/O accesses. Flags are combinational from the
// address, valid, command enables and register state.
module iowin_decoder
    import iowin_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [IDX_W-1:0]  cfg_dw_idx,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              cmd_io_en,
    input  logic              cmd_master_en,
    input  logic              pri_valid,
    input  logic [ADDR_W-1:0] pri_addr,
    output logic              pri_fwd_down,
    input  logic              sec_valid,
    input  logic [ADDR_W-1:0] sec_addr,
    output logic              sec_fwd_up
);
    localparam int SIDES = 2;   // 0 = primary, 1 = secondary

    iowin_cfg_t        cfg_q;
    logic [ADDR_W-1:0] side_addr [SIDES];
    logic [SIDES-1:0]  side_in;
    logic [SIDES-1:0]  side_hole;

    assign side_addr[0] = pri_addr;
    assign side_addr[1] = sec_addr;

    iowin_cfg_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_dw_idx (cfg_dw_idx),
        .cfg_be     (cfg_be),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .cfg_q      (cfg_q)
    );

    genvar s;
    generate
        for (s = 0; s < SIDES; s++) begin : g_side
            iowin_match u_match (
                .cfg      (cfg_q),
                .addr     (side_addr[s]),
                .in_win   (side_in[s]),
                .isa_hole (side_hole[s])
            );
        end
    endgenerate

    // Purpose: downstream decision for the primary side.
    always_comb pri_fwd_down = pri_valid && cmd_io_en && side_in[0] && !side_hole[0];

    // Purpose: upstream decision for the secondary side.
    always_comb sec_fwd_up = sec_valid && cmd_master_en && (!side_in[1] || side_hole[1]);

    logic win_off;
    assign win_off = {cfg_q.base_hi, cfg_q.base_nib} > {cfg_q.lim_hi, cfg_q.lim_nib};

    // R9: downstream needs I/O enable.
    assert_down_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pri_fwd_down |-> (cmd_io_en && pri_valid));
    // R10: upstream needs master enable.
    assert_up_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sec_fwd_up |-> (cmd_master_en && sec_valid));
    // R6: disabled window never forwards downstream.
    assert_win_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        win_off |-> !pri_fwd_down);
    // R5: the same address never goes both ways, nor neither way.
    assert_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pri_valid && sec_valid && cmd_io_en && cmd_master_en && pri_addr == sec_addr)
        |-> (pri_fwd_down != sec_fwd_up));
    // R7: carve-out addresses are not sent downstream.
    assert_isa_hole_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.isa_en && pri_addr[31:16] == 16'h0 && pri_addr[9:8] != 2'b00) |-> !pri_fwd_down);
endmodule

// File: tb/test_iowin_decoder.sv
module test_iowin_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [5:0]  cfg_dw_idx = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        cmd_io_en = 1'b0, cmd_master_en = 1'b0;
    logic        pri_valid = 1'b0, sec_valid = 1'b0;
    logic [31:0] pri_addr = '0, sec_addr = '0;
    logic        pri_fwd_down, sec_fwd_up;

    int n_cmp = 0, n_bad = 0;
    bit checking = 0;
    string cur_req = "R1";

    // reference state
    int unsigned m_bhi = 0, m_bnib = 0, m_lhi = 0, m_lnib = 0;
    bit m_isa = 0;

    always #4 clk = ~clk;   // 125 MHz

    iowin_decoder i_iowin_decoder (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dw_idx(cfg_dw_idx),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .cmd_io_en(cmd_io_en), .cmd_master_en(cmd_master_en),
        .pri_valid(pri_valid), .pri_addr(pri_addr), .pri_fwd_down(pri_fwd_down),
        .sec_valid(sec_valid), .sec_addr(sec_addr), .sec_fwd_up(sec_fwd_up));

    function automatic bit m_inwin(logic [31:0] a);
        longint lo, hi, x;
        lo = longint'(m_bhi) * 65536 + longint'(m_bnib) * 4096;
        hi = longint'(m_lhi) * 65536 + longint'(m_lnib) * 4096 + 4095;
        x  = longint'(a);
        return (x >= lo) && (x <= hi);
    endfunction

    function automatic bit m_hole(logic [31:0] a);
        return m_isa && (a < 32'h1_0000) && ((a % 1024) >= 256);
    endfunction

    function automatic logic [31:0] m_read(logic [5:0] idx);
        case (idx)
            6'h07: return (m_lnib << 12) | (32'h1 << 8) | (m_bnib << 4) | 32'h1;
            6'h0C: return (m_lhi << 16) | m_bhi;
            6'h0F: return m_isa ? 32'h0004_0000 : 32'h0;
            default: return 32'h0;
        endcase
    endfunction

    task automatic cmp(string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    // compare every cycle away from the active edge
    always @(negedge clk) if (checking) begin
        bit ed, eu;
        ed = pri_valid && cmd_io_en && m_inwin(pri_addr) && !m_hole(pri_addr);
        eu = sec_valid && cmd_master_en && (!m_inwin(sec_addr) || m_hole(sec_addr));
        cmp("pri_fwd_down", {31'b0, pri_fwd_down}, {31'b0, ed});
        cmp("sec_fwd_up",   {31'b0, sec_fwd_up},   {31'b0, eu});
        cmp("cfg_rdata", cfg_rdata, m_read(cfg_dw_idx));
    end

    task automatic wr(logic [5:0] idx, logic [3:0] be, logic [31:0] d);
        @(posedge clk); #1;
        cfg_wr = 1; cfg_dw_idx = idx; cfg_be = be; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_wr = 0;
        if (idx == 6'h07) begin
            if (be[0]) m_bnib = d[7:4];
            if (be[1]) m_lnib = d[15:12];
        end else if (idx == 6'h0C) begin
            if (be[0]) m_bhi = (m_bhi & 32'hFF00) | d[7:0];
            if (be[1]) m_bhi = (m_bhi & 32'h00FF) | (32'(d[15:8]) << 8);
            if (be[2]) m_lhi = (m_lhi & 32'hFF00) | d[23:16];
            if (be[3]) m_lhi = (m_lhi & 32'h00FF) | (32'(d[31:24]) << 8);
        end else if (idx == 6'h0F && be[2]) m_isa = d[18];
    endtask

    task automatic window(logic [31:0] b, logic [31:0] l, bit isa);
        wr(6'h07, 4'b0011, {16'h0, l[15:12], 4'h0, b[15:12], 4'h0});
        wr(6'h0C, 4'b1111, {l[31:16], b[31:16]});
        wr(6'h0F, 4'b0100, isa ? 32'h0004_0000 : 32'h0);
    endtask

    task automatic acc(logic [31:0] a, bit pv, bit sv);
        @(posedge clk); #1;
        pri_addr = a; sec_addr = a; pri_valid = pv; sec_valid = sv;
        @(posedge clk);
    endtask

    task automatic rd(logic [5:0] idx);
        @(posedge clk); #1; cfg_dw_idx = idx; @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        checking = 1;
        // R1: reset values and bottom-4KB window
        cur_req = "R1";
        rd(6'h07); rd(6'h0C); rd(6'h0F);
        cmd_io_en = 1; cmd_master_en = 1;
        acc(32'h0000_0FFF, 1, 1); acc(32'h0000_1000, 1, 1);
        // R2: read-only nibbles ignore writes
        cur_req = "R2";
        wr(6'h07, 4'b0011, 32'h0000_0E0E); rd(6'h07);
        // R3: byte lanes
        cur_req = "R3";
        wr(6'h0C, 4'b0001, 32'hAABB_CCDD); rd(6'h0C);
        wr(6'h0C, 4'b1000, 32'h1122_3344); rd(6'h0C);
        wr(6'h07, 4'b0010, 32'h0000_5060); rd(6'h07);
        wr(6'h07, 4'b0001, 32'h0000_7080); rd(6'h07);
        // R4/R5: range edges
        cur_req = "R4_R5";
        window(32'h0012_3000, 32'h0012_5FFF, 0);
        foreach (edges_a[i]) acc(edges_a[i], 1, 1);
        // R6: window off
        cur_req = "R6";
        window(32'h0020_0000, 32'h0010_0FFF, 0);
        acc(32'h0010_0000, 1, 1); acc(32'h0018_0000, 1, 1); acc(32'h0020_0000, 1, 1);
        // R7: ISA carve-out
        cur_req = "R7";
        window(32'h0000_0000, 32'h0001_FFFF, 1); rd(6'h0F);
        foreach (edges_i[i]) acc(edges_i[i], 1, 1);
        // R8: carve-out stops at 64KB
        cur_req = "R8";
        acc(32'h0001_0300, 1, 1); acc(32'h0001_0100, 1, 1); acc(32'h0000_FF00, 1, 1);
        // R12: ISA bit needs lane 2
        cur_req = "R12";
        wr(6'h0F, 4'b1011, 32'h0); rd(6'h0F); acc(32'h0000_0300, 1, 1);
        wr(6'h0F, 4'b0100, 32'h0); rd(6'h0F); acc(32'h0000_0300, 1, 1);
        // R9/R10: command gating
        cur_req = "R9_R10";
        cmd_io_en = 0; acc(32'h0000_0100, 1, 1); acc(32'h0004_0000, 1, 1);
        cmd_io_en = 1; cmd_master_en = 0; acc(32'h0004_0000, 1, 1);
        cmd_master_en = 1;
        // R11: valid qualifies
        cur_req = "R11";
        acc(32'h0000_0100, 0, 0); acc(32'h0004_0000, 0, 0);
        // random mix
        cur_req = "R4_R5_R7_random";
        for (int k = 0; k < 400; k++) begin
            if (k % 40 == 0)
                window($urandom & 32'h0003_F000, ($urandom & 32'h0003_F000) | 32'hFFF, $urandom % 2);
            cmd_io_en = ($urandom % 8) != 0; cmd_master_en = ($urandom % 8) != 0;
            @(posedge clk); #1;
            pri_addr = $urandom & 32'h0003_FFFF; sec_addr = ($urandom % 2) ? pri_addr : ($urandom & 32'h0003_FFFF);
            pri_valid = ($urandom % 4) != 0; sec_valid = ($urandom % 4) != 0;
            cfg_dw_idx = 6'($urandom % 16);
        end
        @(posedge clk);
        checking = 0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    logic [31:0] edges_a [6] = '{32'h0012_2FFF, 32'h0012_3000, 32'h0012_4800,
                                 32'h0012_5FFF, 32'h0012_6000, 32'h0000_0000};
    logic [31:0] edges_i [7] = '{32'h0000_00FF, 32'h0000_0100, 32'h0000_03FF,
                                 32'h0000_0400, 32'h0000_0500, 32'h0000_FCFF, 32'h0000_FFFF};

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule